// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the boundary-scan test port of a synchronous memory device. A serial test clock, mode select and data input drive a sixteen-state test controller. That controller moves bits through one of four shift paths and returns them on a serial output. The paths are a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification word and a 69-cell boundary chain. The boundary chain samples the memory's pins in parallel and presents a latched pattern back toward them.

The decoded instruction chooses the active data path and the state of a high-impedance force for the memory's output drivers. Two of the boundary-chain instructions raise that force and one leaves the memory undisturbed. An asynchronous active-low reset, or five test clocks with mode select held high, returns the port to its idle identity state. The three unassigned instruction codes fall back to the bypass stage.

Top module: `scan_port`

## Requirements
- R1: While `trst_n` is low, and right after it goes low, the port is in the reset state. In that state the instruction is 001, `hiz_force` is 0, `pin_drive` is all zeros, and `tdo` and `tdo_en` are 0.
- R2: Five consecutive rising `tck` edges with `tms` high put the controller into Test-Logic-Reset from any state. After that, a data scan returns the identification word.
- R3: Capture-IR loads 001 into the instruction shift register. An instruction scan therefore shifts out 1, 0, 0 in that order, least significant bit first.
- R4: A shifted instruction takes effect only on the rising edge that leaves Update-IR. Until then `hiz_force` keeps the value set by the previous instruction.
- R5: Code 001 selects the 32-bit identification path, which is captured in Capture-DR and shifted out LSB first. Bits 31:29 hold 000, bits 28:12 hold the device code 01011001000100110, bits 11:1 hold the vendor code 00000110100, and bit 0 is 1.
- R6: Code 111 selects the 1-bit bypass stage. It captures 0, so a data scan returns 0 followed by the `tdi` bits delayed by one clock.
- R7: The unassigned codes 011, 101 and 110 behave like code 111 and keep `hiz_force` at 0.
- R8: Codes 000 and 010 select the 69-cell boundary chain. Capture-DR loads `pin_sample` into it (bit 0 shifts out first), and `hiz_force` is 1.
- R9: Code 100 selects the boundary chain with the same capture as R8, and `hiz_force` is 0.
- R10: `pin_drive` changes only on the rising edge that leaves Update-DR with the boundary chain selected. It then takes the shifted-in chain contents, with the first `tdi` bit in bit 0.
- R11: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.
- R12: Reaching Test-Logic-Reset through `tms` restores instruction 001 and drops `hiz_force` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| pin_sample | input | 69 | Parallel pin states for boundary capture |
| pin_drive | output | 69 | Latched boundary update values |
| hiz_force | output | 1 | Forces memory output drivers to high impedance |

## Verification
A controller in the wrong state shows up within one falling edge: `tdo_en` rises outside a shift or stays low inside one, and the next scan returns a bit stream of the wrong length or content. A corrupted instruction register changes `hiz_force` at once. It also changes which word the very next data scan returns, so a wrong decode is seen within a single scan. A boundary update latch that moves early shows a changed `pin_drive` before Update-DR has been passed.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      SEL_BYP,
      SEL_ID,
      SEL_BND
   } dr_sel_e;

   localparam logic [IR_W-1:0] OP_EXT     = 3'b000;
   localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMP_HZ = 3'b010;
   localparam logic [IR_W-1:0] OP_SAMP    = 3'b100;
   localparam logic [IR_W-1:0] OP_BYP     = 3'b111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
   import scan_port_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state,
   output tap_state_e nxt
);

   always_comb begin
      nxt = ST_RESET;
      case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= nxt;
   end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
   import scan_port_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  tap_state_e      state,
   input  tap_state_e      nxt,
   output logic [IR_W-1:0] ir_shift,
   output logic [IR_W-1:0] ir_cur,
   output dr_sel_e         dr_sel,
   output logic            hiz
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_shift <= IR_CAPTURE;
         ir_cur   <= OP_IDENT;
      end else begin
         case (state)
            ST_CAP_IR: ir_shift <= IR_CAPTURE;
            ST_SHF_IR: ir_shift <= {tdi, ir_shift[IR_W-1:1]};
            default:   ir_shift <= ir_shift;
         endcase
         if (nxt == ST_RESET)        ir_cur <= OP_IDENT;
         else if (state == ST_UPD_IR) ir_cur <= ir_shift;
      end
   end

   // Unassigned codes fall to the bypass stage with drivers untouched.
   always_comb begin
      dr_sel = SEL_BYP;
      hiz    = 1'b0;
      case (ir_cur)
         OP_EXT:     begin dr_sel = SEL_BND; hiz = 1'b1; end
         OP_SAMP_HZ: begin dr_sel = SEL_BND; hiz = 1'b1; end
         OP_SAMP:    dr_sel = SEL_BND;
         OP_IDENT:   dr_sel = SEL_ID;
         OP_BYP:     dr_sel = SEL_BYP;
         default:    dr_sel = SEL_BYP;
      endcase
   end

endmodule

// File: rtl/scan_dr.sv
module scan_dr
   import scan_port_pkg::*;
#(
   parameter int          BND_LEN = 69,
   parameter logic [31:0] ID_WORD = 32'h1
) (
   input  logic               tck,
   input  logic               rst_n,
   input  logic               tdi,
   input  tap_state_e         state,
   input  dr_sel_e            dr_sel,
   input  logic [BND_LEN-1:0] pin_sample,
   output logic [BND_LEN-1:0] pin_drive,
   output logic               dr_lsb
);

   localparam int ID_LEN = 32;

   logic               byp_q;
   logic [ID_LEN-1:0]  id_sh;
   logic [BND_LEN-1:0] bnd_sh;
   logic               cap, shf, upd;
   logic               bnd_cap, bnd_shf, bnd_upd;

   assign cap     = (state == ST_CAP_DR);
   assign shf     = (state == ST_SHF_DR);
   assign upd     = (state == ST_UPD_DR);
   assign bnd_cap = cap && (dr_sel == SEL_BND);
   assign bnd_shf = shf && (dr_sel == SEL_BND);
   assign bnd_upd = upd && (dr_sel == SEL_BND);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b0;
         id_sh <= '0;
      end else begin
         if (dr_sel == SEL_BYP) begin
            if (cap)      byp_q <= 1'b0;
            else if (shf) byp_q <= tdi;
         end
         if (dr_sel == SEL_ID) begin
            if (cap)      id_sh <= ID_WORD;
            else if (shf) id_sh <= {tdi, id_sh[ID_LEN-1:1]};
         end
      end
   end

   for (genvar i = 0; i < BND_LEN; i++) begin : g_cell
      logic sin, sh_q, up_q;
      if (i == BND_LEN - 1) begin : g_head
         assign sin = tdi;
      end else begin : g_link
         assign sin = bnd_sh[i+1];
      end
      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= 1'b0;
            up_q <= 1'b0;
         end else begin
            if (bnd_cap)      sh_q <= pin_sample[i];
            else if (bnd_shf) sh_q <= sin;
            if (bnd_upd)      up_q <= sh_q;
         end
      end
      assign bnd_sh[i]    = sh_q;
      assign pin_drive[i] = up_q;
   end

   always_comb begin
      case (dr_sel)
         SEL_ID:  dr_lsb = id_sh[0];
         SEL_BND: dr_lsb = bnd_sh[0];
         default: dr_lsb = byp_q;
      endcase
   end

endmodule

// File: rtl/scan_port.sv
module scan_port
   import scan_port_pkg::*;
#(
   parameter int          BND_LEN   = 69,
   parameter logic [2:0]  ID_REV    = 3'b000,
   parameter logic [16:0] ID_DEVICE = 17'b01011001000100110,
   parameter logic [10:0] ID_VENDOR = 11'b00000110100
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_en,
   input  logic [BND_LEN-1:0] pin_sample,
   output logic [BND_LEN-1:0] pin_drive,
   output logic               hiz_force
);

   localparam logic [31:0] ID_WORD = {ID_REV, ID_DEVICE, ID_VENDOR, 1'b1};

   initial begin
      assert (BND_LEN >= 2 && BND_LEN <= 4096)
         else $error("scan_port: BND_LEN out of range");
   end

   tap_state_e      state, nxt;
   logic [IR_W-1:0] ir_shift, ir_cur;
   dr_sel_e         dr_sel;
   logic            dr_lsb;

   scan_fsm u_fsm (
      .tck   (tck),
      .rst_n (trst_n),
      .tms   (tms),
      .state (state),
      .nxt   (nxt)
   );

   scan_ir u_ir (
      .tck      (tck),
      .rst_n    (trst_n),
      .tdi      (tdi),
      .state    (state),
      .nxt      (nxt),
      .ir_shift (ir_shift),
      .ir_cur   (ir_cur),
      .dr_sel   (dr_sel),
      .hiz      (hiz_force)
   );

   scan_dr #(
      .BND_LEN (BND_LEN),
      .ID_WORD (ID_WORD)
   ) u_dr (
      .tck        (tck),
      .rst_n      (trst_n),
      .tdi        (tdi),
      .state      (state),
      .dr_sel     (dr_sel),
      .pin_sample (pin_sample),
      .pin_drive  (pin_drive),
      .dr_lsb     (dr_lsb)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else if (state == ST_SHF_IR) begin
         tdo    <= ir_shift[0];
         tdo_en <= 1'b1;
      end else if (state == ST_SHF_DR) begin
         tdo    <= dr_lsb;
         tdo_en <= 1'b1;
      end else begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end
   end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
   import scan_port_pkg::*;
#(
   parameter int BND_LEN = 69
) (
   input logic               tck,
   input logic               trst_n,
   input logic               tms,
   input tap_state_e         state,
   input logic [IR_W-1:0]    ir_cur,
   input logic [IR_W-1:0]    ir_shift,
   input logic               hiz_force,
   input logic               tdo_en,
   input logic [BND_LEN-1:0] pin_drive
);

   logic [2:0] ones;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)          ones <= '0;
      else if (!tms)        ones <= '0;
      else if (ones != 3'd5) ones <= ones + 3'd1;
   end

   assert_tms_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (ones == 3'd5) |-> (state == ST_RESET));

   assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_IR) |=> (ir_shift == 3'b001));

   assert_ir_hold_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_UPD_IR && state != ST_RESET && !(state == ST_SEL_IR && tms))
      |=> $stable(ir_cur));

   assert_update_hold_R10: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_UPD_DR) |=> $stable(pin_drive));

   assert_tdo_window_R11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == ST_SHF_IR || state == ST_SHF_DR));

   assert_reset_release_R12: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |-> (ir_cur == 3'b001 && !hiz_force));

endmodule

bind scan_port scan_port_chk #(.BND_LEN(BND_LEN)) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .tms       (tms),
   .state     (state),
   .ir_cur    (ir_cur),
   .ir_shift  (ir_shift),
   .hiz_force (hiz_force),
   .tdo_en    (tdo_en),
   .pin_drive (pin_drive)
);

// File: tb/scan_port_bench.sv
`timescale 1ns/1ps
module scan_port_bench;

   localparam int N = 69;
   localparam logic [31:0] ID_EXP = {3'b000, 17'b01011001000100110, 11'b00000110100, 1'b1};
   // {code[2:0], hiz, kind[1:0]}  kind: 0 boundary, 1 ident, 2 bypass
   localparam logic [5:0] VEC [0:7] = '{
      {3'b000, 1'b1, 2'd0}, {3'b001, 1'b0, 2'd1},
      {3'b010, 1'b1, 2'd0}, {3'b011, 1'b0, 2'd2},
      {3'b100, 1'b0, 2'd0}, {3'b101, 1'b0, 2'd2},
      {3'b110, 1'b0, 2'd2}, {3'b111, 1'b0, 2'd2}};

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic tdo, tdo_en, hiz_force;
   logic [N-1:0] pin_sample = '0, pin_drive;

   int n_cmp = 0, n_bad = 0, edge_err = 0, en_bad = 0;
   logic last_en;

   scan_port u_scan_port (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .pin_sample(pin_sample), .pin_drive(pin_drive), .hiz_force(hiz_force));

   always #10 tck = ~tck;

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input logic tms_v, input logic tdi_v, output logic tdo_s);
      logic pre;
      tms = tms_v; tdi = tdi_v;
      @(negedge tck); #2;
      tdo_s = tdo; pre = tdo; last_en = tdo_en;
      @(posedge tck); #2;
      if (tdo !== pre) edge_err++;
   endtask

   task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap, output logic hz_mid);
      logic b;
      tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
      for (int i = 0; i < 3; i++) begin
         tick(i == 2, code[i], b);
         cap[i] = b;
         if (!last_en) en_bad++;
      end
      tick(1, 0, b);
      hz_mid = hiz_force;
      tick(0, 0, b);
   endtask

   task automatic dr_scan(input int n, input logic [N-1:0] din,
                          output logic [N-1:0] dout, output logic [N-1:0] pd_mid);
      logic b;
      dout = '0;
      tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i], b);
         dout[i] = b;
         if (!last_en) en_bad++;
      end
      tick(1, 0, b);
      pd_mid = pin_drive;
      tick(0, 0, b);
      if (tdo_en !== 1'b0 || tdo !== 1'b0) en_bad++;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [2:0] cap;
      logic hz_mid, b, prev_hiz;
      logic [N-1:0] dout, pd, din, pat, exp_b;
      string tag;

      repeat (3) @(posedge tck);
      #2;
      chk("R1 hiz in reset", N'(hiz_force), N'(0));
      chk("R1 drive in reset", pin_drive, '0);
      chk("R1 tdo_en in reset", N'({tdo_en, tdo}), N'(0));
      trst_n = 1'b1;
      tick(0, 0, b);

      dr_scan(32, '0, dout, pd);
      chk("R5 R1 default ident word", dout, N'(ID_EXP));

      prev_hiz = 1'b0;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] code;
         logic hz_e;
         logic [1:0] kind;
         {code, hz_e, kind} = VEC[k];
         tag = $sformatf("code %b", code);
         ir_scan(code, cap, hz_mid);
         if (k == 0) chk("R3 captured instruction bits", N'(cap), N'(3'b001));
         chk({"R4 hiz held until update ", tag}, N'(hz_mid), N'(prev_hiz));
         if (kind == 2'd0)
            chk({(code == 3'b100) ? "R9 hiz " : "R8 hiz ", tag}, N'(hiz_force), N'(hz_e));
         else if (kind == 2'd1)
            chk({"R5 hiz ", tag}, N'(hiz_force), N'(hz_e));
         else
            chk({(code == 3'b111) ? "R6 hiz " : "R7 hiz ", tag}, N'(hiz_force), N'(hz_e));
         prev_hiz = hz_e;
         case (kind)
            2'd0: begin
               pat = {5'(k * 3 + 1), 64'hA5C3_0F96_3C5A_E781} ^ (N'(1) << (k * 7));
               din = ~{pat[N-2:0], pat[N-1]};
               pin_sample = pat;
               exp_b = pin_drive;
               dr_scan(N, din, dout, pd);
               chk({(code == 3'b100) ? "R9 boundary capture " : "R8 boundary capture ", tag}, dout, pat);
               chk({"R10 drive held before update ", tag}, pd, exp_b);
               chk({"R10 drive after update ", tag}, pin_drive, din);
            end
            2'd1: begin
               dr_scan(32, '0, dout, pd);
               chk({"R5 ident word ", tag}, dout, N'(ID_EXP));
            end
            default: begin
               din = N'(8'b1011_0010) ^ N'(k);
               exp_b = '0;
               exp_b[8:1] = din[7:0];
               exp_b[0] = 1'b0;
               dr_scan(9, din, dout, pd);
               chk({(code == 3'b111) ? "R6 bypass delay " : "R7 bypass delay ", tag}, dout, exp_b);
            end
         endcase
      end

      // Five ones from the middle of a data shift under a forcing instruction
      ir_scan(3'b000, cap, hz_mid);
      chk("R8 hiz raised before tms reset", N'(hiz_force), N'(1));
      tick(1, 0, b); tick(0, 0, b); tick(0, 0, b); tick(0, 1, b); tick(0, 0, b);
      for (int i = 0; i < 5; i++) tick(1, 0, b);
      chk("R12 hiz released by tms reset", N'(hiz_force), N'(0));
      tick(0, 0, b);
      dr_scan(32, '0, dout, pd);
      chk("R2 ident after five tms ones from shift-dr", dout, N'(ID_EXP));

      // Five ones from the middle of an instruction shift
      tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b); tick(0, 0, b);
      for (int i = 0; i < 5; i++) tick(1, 0, b);
      tick(0, 0, b);
      dr_scan(32, '0, dout, pd);
      chk("R2 ident after five tms ones from shift-ir", dout, N'(ID_EXP));

      // Asynchronous reset mid-cycle
      ir_scan(3'b010, cap, hz_mid);
      chk("R8 sample-hz raises hiz", N'(hiz_force), N'(1));
      #3 trst_n = 1'b0;
      #1;
      chk("R1 async reset drops hiz", N'(hiz_force), N'(0));
      chk("R1 async reset clears drive", pin_drive, '0);
      @(posedge tck); #2;
      trst_n = 1'b1;
      tick(0, 0, b);
      dr_scan(32, '0, dout, pd);
      chk("R1 ident after async reset", dout, N'(ID_EXP));

      chk("R11 tdo moved on rising edge", N'(edge_err), N'(0));
      chk("R11 tdo_en window", N'(en_bad), N'(0));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule